// File: doc/BRIEF.md
# Banked program memory mapper

This block sits between a CPU address bus and the program memories of a cartridge-style system. It divides the CPU range 0x8000 to 0xFFFF into four 8 KB windows. A two-bit mode sets how four bank registers fill those windows: one 32 KB page, two 16 KB pages, a 16 KB page with two 8 KB pages, or four 8 KB pages. A separate 8 KB window at 0x6000 always holds battery RAM. For each access the block produces a translated memory address, a ROM or RAM select, and read and write enables for the external memories. It does not contain the memories.

Several windows can hold either ROM or RAM, chosen by bit 7 of the bank value. A RAM bank number passes through a translation table that the RAM-size parameter picks, and that table can mark a bank as absent. A read from a window with no backing memory drives the open-bus value, which is the upper byte of the CPU address. A RAM write goes through only when two protection registers hold their unlock values.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset the mode is four 8 KB windows and all four bank registers are 0xFF, so a read anywhere in 0x8000-0xFFFF selects ROM bank 0x7F (mem_addr = 0x7F*8192 + addr[12:0]).
- R2: In four-8 KB mode (mode value 3) the windows at 0x8000, 0xA000 and 0xC000 use bank registers 0, 1 and 2. A value with bit 7 set selects ROM bank value[6:0], and a value with bit 7 clear selects RAM through the table. The 0xE000 window is always ROM at bank register 3 bits [6:0].
- R3: In 32 KB mode (mode value 0) every window is ROM, with 8 KB index {reg3[6:2], addr[14:13]}, whatever bit 7 of any register holds.
- R4: In 16 KB mode (mode value 1) the lower half uses value {reg1[7:1], addr[13]} under the bit-7 ROM/RAM rule. The upper half is always ROM at index {reg3[6:1], addr[13]}.
- R5: In 16 KB + 8 KB mode (mode value 2) the lower half behaves as in R4. The 0xC000 window uses register 2 under the bit-7 rule, and 0xE000 is ROM at reg3[6:0].
- R6: A RAM bank number n (the low 3 bits) is translated by the RAM-size parameter. For 32 KB, banks 0-3 map to 0-3 and banks 4-7 are invalid. For 16 KB, banks 0-3 map to 0 and banks 4-7 map to 1. A valid RAM mapping drives ram_sel with mem_addr = bank*8192 + addr[12:0].
- R7: The 0x6000-0x7FFF window is always RAM. Its bank is the register at 0x5113, low 3 bits, passed through the same table.
- R8: A read from a window whose RAM bank is invalid asserts bus_float with float_data = addr[15:8], and leaves rom_sel, ram_sel and mem_rd low.
- R9: mem_wr is asserted only for a write to a valid RAM mapping while register 0x5102 holds exactly 0x02 and register 0x5103 holds exactly 0x01. A write to a ROM window never asserts mem_wr.
- R10: The registers are mode at 0x5100 (bits 1:0), protection at 0x5102 and 0x5103, the 0x6000 bank at 0x5113, and banks 0-3 at 0x5114-0x5117. A write takes effect for an access in the following cycle, and a write to any other address changes no mapping. The outputs for an access appear one clock after it is presented.
- R11: Accesses below 0x6000 produce no select, no memory enable and no bus_float.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data (used for register writes) |
| cpu_rd | input | 1 | CPU read strobe for this cycle |
| cpu_wr | input | 1 | CPU write strobe for this cycle |
| rom_sel | output | 1 | Access maps to ROM (registered) |
| ram_sel | output | 1 | Access maps to a valid RAM bank (registered) |
| mem_addr | output | 20 | Translated memory address: bank index times 8 KB plus offset |
| mem_rd | output | 1 | Read enable to the selected memory |
| mem_wr | output | 1 | Write enable to RAM, protection satisfied |
| bus_float | output | 1 | Read hit an unmapped window; drive open bus |
| float_data | output | 8 | Open-bus value, the upper address byte |

## Verification
Assertions check on every cycle that ROM and RAM selects never coincide, that a write enable appears only with a RAM select and never with a ROM select, that the open-bus flag excludes every memory enable and carries the upper address byte, that reads of the 0xE000 window always reach ROM, and that accesses below 0x6000 stay silent. Only the bench scenarios can show the actual bank arithmetic of each mode, the translation for the two RAM sizes, the exact unlock values, and that register writes land one cycle later.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int BANK_W    = 8;
  localparam int ROM_IDX_W = BANK_W - 1;
  localparam int RAM_SEL_W = 3;

  localparam int RAM_NONE = 0;
  localparam int RAM_8K   = 1;
  localparam int RAM_16K  = 2;
  localparam int RAM_32K  = 3;
  localparam int RAM_40K  = 4;
  localparam int RAM_64K  = 5;

  typedef enum logic [1:0] {
    MODE_32K   = 2'd0,
    MODE_16K   = 2'd1,
    MODE_16K8K = 2'd2,
    MODE_8K    = 2'd3
  } prg_mode_e;

  typedef struct packed {
    logic                 valid;
    logic [RAM_SEL_W-1:0] bank;
  } ram_map_t;

  // RAM bank translation for a given fitted RAM size
  function automatic ram_map_t ram_xlate(input int cfg, input logic [RAM_SEL_W-1:0] sel);
    ram_map_t r;
    r.valid = 1'b0;
    r.bank  = '0;
    case (cfg)
      RAM_8K:  begin r.valid = ~sel[2]; r.bank = '0; end
      RAM_16K: begin r.valid = 1'b1;    r.bank = {2'b00, sel[2]}; end
      RAM_32K: begin r.valid = ~sel[2]; r.bank = {1'b0, sel[1:0]}; end
      RAM_40K: begin r.valid = 1'b1;    r.bank = sel[2] ? 3'd4 : {1'b0, sel[1:0]}; end
      RAM_64K: begin r.valid = 1'b1;    r.bank = sel; end
      default: begin r.valid = 1'b0;    r.bank = '0; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/prg_regfile.sv
module prg_regfile
  import prg_map_pkg::*;
#(
  parameter logic [15:0] REG_BASE = 16'h5100
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [15:0]                cpu_addr,
  input  logic [BANK_W-1:0]          cpu_wdata,
  input  logic                       cpu_wr,
  output logic [1:0]                 mode,
  output logic [2:0][BANK_W-1:0]     bank_lo,
  output logic [ROM_IDX_W-1:0]       bank_hi,
  output logic [RAM_SEL_W-1:0]       ram_win,
  output logic                       unlocked
);
  localparam logic [15:0] A_MODE  = REG_BASE + 16'h0000;
  localparam logic [15:0] A_PROTA = REG_BASE + 16'h0002;
  localparam logic [15:0] A_PROTB = REG_BASE + 16'h0003;
  localparam logic [15:0] A_RAMW  = REG_BASE + 16'h0013;
  localparam logic [15:0] A_BANK  = REG_BASE + 16'h0014;
  localparam logic [BANK_W-1:0] KEY_A = 8'h02;
  localparam logic [BANK_W-1:0] KEY_B = 8'h01;

  logic [BANK_W-1:0] prot_a, prot_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MODE_8K;
      bank_hi <= '1;
      ram_win <= '0;
      prot_a  <= '0;
      prot_b  <= '0;
    end else if (cpu_wr) begin
      if (cpu_addr == A_MODE)           mode    <= cpu_wdata[1:0];
      if (cpu_addr == A_PROTA)          prot_a  <= cpu_wdata;
      if (cpu_addr == A_PROTB)          prot_b  <= cpu_wdata;
      if (cpu_addr == A_RAMW)           ram_win <= cpu_wdata[RAM_SEL_W-1:0];
      if (cpu_addr == A_BANK + 16'd3)   bank_hi <= cpu_wdata[ROM_IDX_W-1:0];
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        bank_lo[i] <= '1;
      else if (cpu_wr && cpu_addr == A_BANK + 16'(i))
        bank_lo[i] <= cpu_wdata;
    end
  end

  assign unlocked = (prot_a == KEY_A) && (prot_b == KEY_B);
endmodule

// File: rtl/prg_window_decode.sv
module prg_window_decode
  import prg_map_pkg::*;
#(
  parameter int RAM_CFG = RAM_32K
) (
  input  logic [2:0]                 addr_hi,
  input  logic [1:0]                 mode,
  input  logic [2:0][BANK_W-1:0]     bank_lo,
  input  logic [ROM_IDX_W-1:0]       bank_hi,
  input  logic [RAM_SEL_W-1:0]       ram_win,
  output logic                       in_range,
  output logic                       is_rom,
  output logic                       is_ram,
  output logic [ROM_IDX_W-1:0]       idx
);
  logic [1:0]        win;
  logic [BANK_W-1:0] val;
  logic              flagged;
  ram_map_t          xl;

  assign win = addr_hi[1:0];

  always_comb begin
    in_range = addr_hi[2] | (addr_hi == 3'b011);
    is_rom   = 1'b0;
    is_ram   = 1'b0;
    idx      = '0;
    val      = '0;
    flagged  = 1'b0;
    xl       = '0;
    if (!addr_hi[2]) begin
      xl     = ram_xlate(RAM_CFG, ram_win);
      is_ram = in_range & xl.valid;
      idx    = {{(ROM_IDX_W-RAM_SEL_W){1'b0}}, xl.bank};
    end else begin
      case (mode)
        MODE_32K: begin
          is_rom = 1'b1;
          idx    = {bank_hi[6:2], win};
        end
        MODE_16K: begin
          if (!win[1]) begin
            flagged = 1'b1;
            val     = {bank_lo[1][7:1], win[0]};
          end else begin
            is_rom = 1'b1;
            idx    = {bank_hi[6:1], win[0]};
          end
        end
        MODE_16K8K: begin
          if (!win[1]) begin
            flagged = 1'b1;
            val     = {bank_lo[1][7:1], win[0]};
          end else if (!win[0]) begin
            flagged = 1'b1;
            val     = bank_lo[2];
          end else begin
            is_rom = 1'b1;
            idx    = bank_hi;
          end
        end
        default: begin
          case (win)
            2'd0: begin flagged = 1'b1; val = bank_lo[0]; end
            2'd1: begin flagged = 1'b1; val = bank_lo[1]; end
            2'd2: begin flagged = 1'b1; val = bank_lo[2]; end
            default: begin is_rom = 1'b1; idx = bank_hi; end
          endcase
        end
      endcase
      if (flagged) begin
        if (val[7]) begin
          is_rom = 1'b1;
          idx    = val[6:0];
        end else begin
          xl     = ram_xlate(RAM_CFG, val[2:0]);
          is_ram = xl.valid;
          idx    = {{(ROM_IDX_W-RAM_SEL_W){1'b0}}, xl.bank};
        end
      end
    end
  end
endmodule

// File: rtl/prg_access_gate.sv
module prg_access_gate
  import prg_map_pkg::*;
#(
  parameter int WIN_AW = 13,
  localparam int MEM_AW = ROM_IDX_W + WIN_AW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [15:0]          cpu_addr,
  input  logic                 cpu_rd,
  input  logic                 cpu_wr,
  input  logic                 in_range,
  input  logic                 is_rom,
  input  logic                 is_ram,
  input  logic [ROM_IDX_W-1:0] idx,
  input  logic                 unlocked,
  output logic                 rom_sel,
  output logic                 ram_sel,
  output logic [MEM_AW-1:0]    mem_addr,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic                 bus_float,
  output logic [7:0]           float_data
);
  logic acc, hit, miss;

  assign acc  = (cpu_rd | cpu_wr) & in_range;
  assign hit  = is_rom | is_ram;
  assign miss = cpu_rd & in_range & ~hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_sel    <= 1'b0;
      ram_sel    <= 1'b0;
      mem_addr   <= '0;
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      bus_float  <= 1'b0;
      float_data <= '0;
    end else begin
      rom_sel    <= acc & is_rom;
      ram_sel    <= acc & is_ram;
      mem_addr   <= {idx, cpu_addr[WIN_AW-1:0]};
      mem_rd     <= cpu_rd & in_range & hit;
      mem_wr     <= cpu_wr & in_range & is_ram & unlocked;
      bus_float  <= miss;
      float_data <= miss ? cpu_addr[15:8] : 8'h00;
    end
  end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int          RAM_CFG  = RAM_32K,
  parameter int          WIN_AW   = 13,
  parameter logic [15:0] REG_BASE = 16'h5100,
  localparam int         MEM_AW   = ROM_IDX_W + WIN_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              bus_float,
  output logic [7:0]        float_data
);
  logic [1:0]             mode;
  logic [2:0][BANK_W-1:0] bank_lo;
  logic [ROM_IDX_W-1:0]   bank_hi;
  logic [RAM_SEL_W-1:0]   ram_win;
  logic                   unlocked;
  logic                   in_range, is_rom, is_ram;
  logic [ROM_IDX_W-1:0]   idx;

  prg_regfile #(.REG_BASE(REG_BASE)) u_regs (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .mode(mode), .bank_lo(bank_lo), .bank_hi(bank_hi),
    .ram_win(ram_win), .unlocked(unlocked)
  );

  prg_window_decode #(.RAM_CFG(RAM_CFG)) u_dec (
    .addr_hi(cpu_addr[15:13]), .mode(mode), .bank_lo(bank_lo),
    .bank_hi(bank_hi), .ram_win(ram_win), .in_range(in_range),
    .is_rom(is_rom), .is_ram(is_ram), .idx(idx)
  );

  prg_access_gate #(.WIN_AW(WIN_AW)) u_gate (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .in_range(in_range), .is_rom(is_rom), .is_ram(is_ram),
    .idx(idx), .unlocked(unlocked), .rom_sel(rom_sel), .ram_sel(ram_sel),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .bus_float(bus_float), .float_data(float_data)
  );
endmodule

// File: rtl/prg_map_chk.sv
module prg_map_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic        rom_sel,
  input logic        ram_sel,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        bus_float,
  input logic [7:0]  float_data
);
  a_r2_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_sel, ram_sel}));

  a_r2_top_is_rom: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr && cpu_addr[15:13] == 3'b111) |=> (rom_sel && mem_rd));

  a_r8_float_alone: assert property (@(posedge clk) disable iff (rst)
    bus_float |-> (!rom_sel && !ram_sel && !mem_rd && !mem_wr));

  a_r8_float_byte: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr) |=> (!bus_float || float_data == $past(cpu_addr[15:8])));

  a_r9_wr_needs_ram: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (ram_sel && !rom_sel));

  a_r11_low_quiet: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr < 16'h6000) |=> (!rom_sel && !ram_sel && !bus_float && !mem_rd && !mem_wr));
endmodule

bind prg_bank_mapper prg_map_chk u_chk (.*);

// File: tb/tb_prg_bank_mapper.sv
module tb_prg_bank_mapper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;

  logic        rom_sel, ram_sel, mem_rd, mem_wr, bus_float;
  logic [19:0] mem_addr;
  logic [7:0]  float_data;
  logic        s_rom, s_ram, s_rd, s_wr, s_float;
  logic [19:0] s_addr;
  logic [7:0]  s_fdata;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prg_bank_mapper #(.RAM_CFG(3)) dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_sel(rom_sel), .ram_sel(ram_sel),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .bus_float(bus_float), .float_data(float_data));

  prg_bank_mapper #(.RAM_CFG(2)) dut_s (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_sel(s_rom), .ram_sel(s_ram),
    .mem_addr(s_addr), .mem_rd(s_rd), .mem_wr(s_wr),
    .bus_float(s_float), .float_data(s_fdata));

  function automatic logic [19:0] ea(input int bank, input logic [15:0] a);
    return 20'(bank * 8192) + 20'(a[12:0]);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  // present one access; outputs are sampled one clock later
  task automatic access(input logic [15:0] a, input bit wr);
    @(negedge clk);
    cpu_addr = a; cpu_rd = !wr; cpu_wr = wr; cpu_wdata = 8'h5A;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic exp_rom(input string tag, input logic [19:0] ad);
    check({tag, " rom_sel"}, rom_sel, 1);
    check({tag, " ram_sel"}, ram_sel, 0);
    check({tag, " addr"}, mem_addr, ad);
  endtask

  task automatic exp_ram(input string tag, input logic [19:0] ad);
    check({tag, " ram_sel"}, ram_sel, 1);
    check({tag, " rom_sel"}, rom_sel, 0);
    check({tag, " addr"}, mem_addr, ad);
  endtask

  task automatic t_reset();
    check("R1 idle rom_sel", rom_sel, 0);
    check("R1 idle float", bus_float, 0);
    access(16'h8000, 0); exp_rom("R1 8000", ea(8'h7F, 16'h8000));
    check("R1 rd", mem_rd, 1);
    access(16'hA123, 0); exp_rom("R1 A123", ea(8'h7F, 16'hA123));
    access(16'hE456, 0); exp_rom("R1 E456", ea(8'h7F, 16'hE456));
  endtask

  task automatic t_mode8k();
    reg_wr(16'h5114, 8'h85); access(16'h8010, 0); exp_rom("R2 w0 rom", ea(5, 16'h8010));
    reg_wr(16'h5115, 8'h02); access(16'hA004, 0); exp_ram("R2 w1 ram", ea(2, 16'hA004));
    reg_wr(16'h5116, 8'h81); access(16'hC000, 0); exp_rom("R2 w2 rom", ea(1, 16'hC000));
    reg_wr(16'h5117, 8'h03); access(16'hE001, 0); exp_rom("R2 top forced rom", ea(3, 16'hE001));
  endtask

  task automatic t_regs();
    reg_wr(16'h5114, 8'h86);
    access(16'h8000, 0); exp_rom("R10 next cycle", ea(6, 16'h8000));
    reg_wr(16'h5118, 8'h00);
    access(16'hE000, 0); exp_rom("R10 stray write ignored", ea(3, 16'hE000));
    reg_wr(16'h5101, 8'h00);
    access(16'h8000, 0); exp_rom("R10 5101 not mode", ea(6, 16'h8000));
  endtask

  task automatic t_mode32k();
    reg_wr(16'h5100, 8'h00);
    access(16'hA000, 0); exp_rom("R3 reg3=03", ea(1, 16'hA000));
    reg_wr(16'h5117, 8'h0D);
    access(16'hC005, 0); exp_rom("R3 C005", ea(14, 16'hC005));
    access(16'hA000, 0); exp_rom("R3 A000 ignores ram reg", ea(13, 16'hA000));
    access(16'h8000, 0); exp_rom("R3 8000", ea(12, 16'h8000));
  endtask

  task automatic t_mode16k();
    reg_wr(16'h5100, 8'h01);
    reg_wr(16'h5115, 8'h04);
    access(16'h8000, 0);
    check("R8 float", bus_float, 1);
    check("R8 float data", float_data, 8'h80);
    check("R8 no rd", mem_rd, 0);
    check("R8 no sel", ram_sel | rom_sel, 0);
    check("R6 16K cfg bank4->1 sel", s_ram, 1);
    check("R6 16K cfg bank4->1 addr", s_addr, ea(1, 16'h8000));
    access(16'hA000, 0);
    check("R6 16K cfg bank5->1", s_addr, ea(1, 16'hA000));
    check("R6 32K cfg bank5 invalid", bus_float, 1);
    check("R8 float data A0", float_data, 8'hA0);
    reg_wr(16'h5115, 8'h8A);
    access(16'h8000, 0); exp_rom("R4 low even", ea(8'h0A, 16'h8000));
    access(16'hA000, 0); exp_rom("R4 low odd", ea(8'h0B, 16'hA000));
    access(16'hC000, 0); exp_rom("R4 high even", ea(12, 16'hC000));
    access(16'hE000, 0); exp_rom("R4 high odd", ea(13, 16'hE000));
  endtask

  task automatic t_mode16k8k();
    reg_wr(16'h5100, 8'h02);
    reg_wr(16'h5116, 8'h01);
    access(16'hC002, 0); exp_ram("R5 C000 ram", ea(1, 16'hC002));
    check("R6 16K cfg bank1->0", s_addr, ea(0, 16'hC002));
    access(16'hE000, 0); exp_rom("R5 E000", ea(13, 16'hE000));
    access(16'hA010, 0); exp_rom("R5 A000", ea(8'h0B, 16'hA010));
  endtask

  task automatic t_win6000();
    reg_wr(16'h5113, 8'h02);
    access(16'h6010, 0); exp_ram("R7 6000 bank2", ea(2, 16'h6010));
    reg_wr(16'h5113, 8'h06);
    access(16'h7010, 0);
    check("R7 6000 invalid float", bus_float, 1);
    check("R7 float data", float_data, 8'h70);
    check("R7 16K cfg bank6->1", s_addr, ea(1, 16'h7010));
    check("R7 16K cfg sel", s_ram, 1);
  endtask

  task automatic t_protect();
    reg_wr(16'h5100, 8'h03);
    reg_wr(16'h5114, 8'h01);
    access(16'h8000, 1);
    check("R9 locked sel", ram_sel, 1);
    check("R9 locked wr", mem_wr, 0);
    reg_wr(16'h5102, 8'h02);
    access(16'h8000, 1); check("R9 one key wr", mem_wr, 0);
    reg_wr(16'h5103, 8'h01);
    access(16'h8003, 1);
    check("R9 unlocked wr", mem_wr, 1);
    check("R9 unlocked addr", mem_addr, ea(1, 16'h8003));
    access(16'hE000, 1);
    check("R9 rom write blocked", mem_wr, 0);
    check("R9 rom write sel", rom_sel, 1);
    access(16'h6000, 1);
    check("R9 invalid ram write", mem_wr, 0);
    check("R9 invalid ram sel", ram_sel, 0);
    reg_wr(16'h5102, 8'h03);
    access(16'h8000, 1); check("R9 wrong key wr", mem_wr, 0);
  endtask

  task automatic t_low();
    access(16'h5FFF, 0);
    check("R11 5FFF sel", rom_sel | ram_sel, 0);
    check("R11 5FFF float", bus_float, 0);
    access(16'h4000, 1);
    check("R11 4000 wr", mem_wr | mem_rd, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mode8k();
    t_regs();
    t_mode32k();
    t_mode16k();
    t_mode16k8k();
    t_win6000();
    t_protect();
    t_low();
    finish_run();
  end
endmodule